// File: doc/BRIEF.md
# NAND Timing Cycle Calculator

This unit converts a set of NAND flash interface timing limits, given in picoseconds, into whole controller clock counts for the six programmable timing fields of a static memory controller. The fields are command-latch-to-read-enable delay, address-latch-to-read-enable delay, setup, wait, hold and bus high-impedance. The clock period comes in whole nanoseconds. Each limit is first truncated to whole nanoseconds, then divided by the period with rounding up. A per-field rule then subtracts one, forces a minimum of one, and saturates to the width of the field.

A one-cycle `start_i` pulse captures the inputs. A single shared restoring divider then works through the fields one after another. A one-cycle `done_o` pulse marks the end. On success the unit publishes a packed control word and a packed timing word. A parameter set whose read cycle time is too short is rejected with `err_o`, and the words published earlier stay as they are.

Top module: `nand_tcalc`

## Requirements
- R1: A `start_i` pulse while idle begins a computation. `busy_o` is high from the next cycle until the result is ready. `done_o` is then high for exactly one cycle, and `busy_o` is low in that cycle.
- R2: When `trc_min_i` is below 30000 ps, the request is rejected. `done_o` pulses with `err_o`=1, and both output words keep their previous values. A value of exactly 30000 is accepted with `err_o`=0.
- R3: Every picosecond source is truncated to whole nanoseconds (floor of ps/1000) and then divided by `period_ns_i` with rounding up. A difference of two limits that would be negative is taken as zero.
- R4: The command-to-read-enable count comes from `tclr_min_i`, and the address-to-read-enable count comes from `tar_min_i`. Each is the rounded-up quotient minus one, taken as zero when the quotient is zero, and saturated to 15.
- R5: The high-impedance count is the rounded-up quotient of max(tCS−tWP, 0), saturated to 255. It may be zero.
- R6: The hold count is the rounded-up quotient of the largest of the tDH, tCH, tCLH, tWH, tALH and tREH limits. A zero result is raised to 1, and the count saturates at 255.
- R7: The wait count is the rounded-up quotient of max(tRP, tWP), minus one. A zero result is raised to 1, and the count saturates at 255.
- R8: The setup count is the rounded-up quotient of max(tCS−tWP, tCEA−tREA), minus one. A zero result is raised to 1, and the count saturates at 255.
- R9: The timing word holds setup in bits 7:0, wait in bits 15:8, hold in bits 23:16 and high-impedance in bits 31:24.
- R10: The control word has bit 1 (wait-on), bit 2 (enable) and bit 3 (NAND device type) set, and bit 4 equal to `bus16_i`. The command-to-read-enable count sits in bits 12:9 and the address-to-read-enable count in bits 16:13. All other bits are zero.
- R11: A `start_i` pulse while busy is ignored. Input changes after the accepted start do not affect the result.
- R12: After reset, `busy_o`, `done_o` and `err_o` are low, and both words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin computation (one-cycle pulse) |
| period_ns_i | input | PER_W | Controller clock period in ns |
| bus16_i | input | 1 | 16-bit device bus |
| trc_min_i | input | PS_W | Read cycle minimum, ps |
| tar_min_i | input | PS_W | Address latch to read enable minimum, ps |
| tclr_min_i | input | PS_W | Command latch to read enable minimum, ps |
| tcs_min_i | input | PS_W | Chip select setup minimum, ps |
| twp_min_i | input | PS_W | Write pulse minimum, ps |
| tdh_min_i | input | PS_W | Data hold minimum, ps |
| tch_min_i | input | PS_W | Chip select hold minimum, ps |
| tclh_min_i | input | PS_W | Command latch hold minimum, ps |
| twh_min_i | input | PS_W | Write high minimum, ps |
| talh_min_i | input | PS_W | Address latch hold minimum, ps |
| treh_min_i | input | PS_W | Read high minimum, ps |
| trp_min_i | input | PS_W | Read pulse minimum, ps |
| tcea_max_i | input | PS_W | Chip enable access maximum, ps |
| trea_max_i | input | PS_W | Read enable access maximum, ps |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | Result or rejection ready (one cycle) |
| err_o | output | 1 | Last request rejected |
| ctrl_word_o | output | 32 | Packed control word |
| tim_word_o | output | 32 | Packed timing word |

## Verification
The assertions check the following on every cycle:
- `done_o` is a single-cycle pulse, and `busy_o` is low whenever it is high.
- The output words never change while busy, and they do not move when a rejection completes.
- A configured control word always has the fixed flag bits set and the reserved bits clear.
- The setup, wait and hold fields of a configured word are never zero.

The values of the counts themselves can only be shown by the bench's scenarios. These cover the subtract-one and force-to-one rules, saturation at 15 and 255, truncation of sub-nanosecond parts, and negative differences taken as zero. The bench's scenarios also cover the 30000 ps rejection boundary and a second start issued in the middle of a computation.

// File: rtl/nand_tcalc_pkg.sv
package nand_tcalc_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int CNT_W      = 8;
  localparam int PS_PER_NS  = 1000;

  typedef enum logic [2:0] {
    F_CLR   = 3'd0,
    F_ALE   = 3'd1,
    F_HIZ   = 3'd2,
    F_HOLD  = 3'd3,
    F_WAIT  = 3'd4,
    F_SETUP = 3'd5
  } field_e;

  typedef struct packed {
    logic sub_one;
    logic force_one;
    logic narrow;
  } rule_t;

  function automatic rule_t field_rule(field_e f);
    rule_t r;
    case (f)
      F_CLR, F_ALE:    r = '{sub_one: 1'b1, force_one: 1'b0, narrow: 1'b1};
      F_HIZ:           r = '{sub_one: 1'b0, force_one: 1'b0, narrow: 1'b0};
      F_HOLD:          r = '{sub_one: 1'b0, force_one: 1'b1, narrow: 1'b0};
      F_WAIT, F_SETUP: r = '{sub_one: 1'b1, force_one: 1'b1, narrow: 1'b0};
      default:         r = '{sub_one: 1'b0, force_one: 1'b0, narrow: 1'b0};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/nand_tcalc_src.sv
module nand_tcalc_src
  import nand_tcalc_pkg::*;
#(
  parameter int PS_W      = 20,
  parameter int MIN_RC_PS = 30000
) (
  input  logic [PS_W-1:0]                 trc_i,
  input  logic [PS_W-1:0]                 tar_i,
  input  logic [PS_W-1:0]                 tclr_i,
  input  logic [PS_W-1:0]                 tcs_i,
  input  logic [PS_W-1:0]                 twp_i,
  input  logic [PS_W-1:0]                 tdh_i,
  input  logic [PS_W-1:0]                 tch_i,
  input  logic [PS_W-1:0]                 tclh_i,
  input  logic [PS_W-1:0]                 twh_i,
  input  logic [PS_W-1:0]                 talh_i,
  input  logic [PS_W-1:0]                 treh_i,
  input  logic [PS_W-1:0]                 trp_i,
  input  logic [PS_W-1:0]                 tcea_i,
  input  logic [PS_W-1:0]                 trea_i,
  output logic                            rc_ok_o,
  output logic [NUM_FIELDS-1:0][PS_W-1:0] src_o
);
  localparam int NHOLD = 6;

  logic [PS_W-1:0] hiz_src, acc_src, hold_src, wait_src;
  logic [NHOLD-1:0][PS_W-1:0] hold_set;

  assign hold_set = {tdh_i, tch_i, tclh_i, twh_i, talh_i, treh_i};

  // differences that would go negative clamp to zero
  assign hiz_src  = (tcs_i > twp_i) ? tcs_i - twp_i : '0;
  assign acc_src  = (tcea_i > trea_i) ? tcea_i - trea_i : '0;
  assign wait_src = (trp_i > twp_i) ? trp_i : twp_i;

  always_comb begin
    hold_src = '0;
    for (int k = 0; k < NHOLD; k++)
      if (hold_set[k] > hold_src) hold_src = hold_set[k];
  end

  assign rc_ok_o = trc_i >= PS_W'(MIN_RC_PS);

  always_comb begin
    src_o          = '0;
    src_o[F_CLR]   = tclr_i;
    src_o[F_ALE]   = tar_i;
    src_o[F_HIZ]   = hiz_src;
    src_o[F_HOLD]  = hold_src;
    src_o[F_WAIT]  = wait_src;
    src_o[F_SETUP] = (hiz_src > acc_src) ? hiz_src : acc_src;
  end
endmodule

// File: rtl/nand_tcalc_div.sv
module nand_tcalc_div #(
  parameter int NW = 20,
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [NW-1:0] quot_o
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem_q, den_q;
  logic [NW-1:0] quo_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [DW:0]   shifted;
  logic [DW+1:0] diff;
  logic          borrow;

  assign shifted = {rem_q, quo_q[NW-1]};
  assign diff    = {1'b0, shifted} - {2'b00, den_q};
  assign borrow  = diff[DW+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        rem_q <= '0;
        den_q <= den_i;
        quo_q <= num_i;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= borrow ? shifted[DW-1:0] : diff[DW-1:0];
        quo_q <= {quo_q[NW-2:0], ~borrow};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(NW - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
endmodule

// File: rtl/nand_tcalc_rule.sv
module nand_tcalc_rule
  import nand_tcalc_pkg::*;
#(
  parameter int NW       = 20,
  parameter int NARROW_W = 4
) (
  input  logic [2:0]       field_i,
  input  logic [NW-1:0]    ceil_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [NW-1:0] NARROW_MAX = NW'((1 << NARROW_W) - 1);
  localparam logic [NW-1:0] WIDE_MAX   = NW'((1 << CNT_W) - 1);

  rule_t         rule;
  logic [NW-1:0] v_sub, v_min, lim;

  assign rule  = field_rule(field_e'(field_i));
  assign v_sub = (rule.sub_one && ceil_i != '0) ? ceil_i - 1'b1 :
                 rule.sub_one ? '0 : ceil_i;
  assign v_min = (rule.force_one && v_sub == '0) ? NW'(1) : v_sub;
  assign lim   = rule.narrow ? NARROW_MAX : WIDE_MAX;
  assign cnt_o = (v_min > lim) ? lim[CNT_W-1:0] : v_min[CNT_W-1:0];
endmodule

// File: rtl/nand_tcalc.sv
module nand_tcalc
  import nand_tcalc_pkg::*;
#(
  parameter int PS_W      = 20,
  parameter int PER_W     = 8,
  parameter int MIN_RC_PS = 30000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PER_W-1:0] period_ns_i,
  input  logic             bus16_i,
  input  logic [PS_W-1:0]  trc_min_i,
  input  logic [PS_W-1:0]  tar_min_i,
  input  logic [PS_W-1:0]  tclr_min_i,
  input  logic [PS_W-1:0]  tcs_min_i,
  input  logic [PS_W-1:0]  twp_min_i,
  input  logic [PS_W-1:0]  tdh_min_i,
  input  logic [PS_W-1:0]  tch_min_i,
  input  logic [PS_W-1:0]  tclh_min_i,
  input  logic [PS_W-1:0]  twh_min_i,
  input  logic [PS_W-1:0]  talh_min_i,
  input  logic [PS_W-1:0]  treh_min_i,
  input  logic [PS_W-1:0]  trp_min_i,
  input  logic [PS_W-1:0]  tcea_max_i,
  input  logic [PS_W-1:0]  trea_max_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [31:0]      ctrl_word_o,
  output logic [31:0]      tim_word_o
);
  localparam int NW      = PS_W;
  localparam int NS_BITS = $clog2(PS_PER_NS + 1);
  localparam int DW      = (PER_W > NS_BITS) ? PER_W : NS_BITS;
  localparam logic [2:0] LAST_FLD = 3'(NUM_FIELDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_DIV_NS, S_DIV_CK, S_PACK} state_e;

  state_e                          st_q;
  logic [2:0]                      fld_q;
  logic                            go_q, done_q, err_q, bus16_q;
  logic [PER_W-1:0]                per_q;
  logic [NUM_FIELDS-1:0][PS_W-1:0] src_q, src_d;
  logic [NUM_FIELDS-1:0][CNT_W-1:0] cnt_q;
  logic [NW-1:0]                   ns_q, ceil_num, div_num, quot;
  logic [DW-1:0]                   div_den;
  logic                            div_done, rc_ok;
  logic [CNT_W-1:0]                rule_cnt;
  logic [31:0]                     ctrl_q, tim_q;

  nand_tcalc_src #(.PS_W(PS_W), .MIN_RC_PS(MIN_RC_PS)) u_src (
    .trc_i (trc_min_i),  .tar_i (tar_min_i),  .tclr_i(tclr_min_i),
    .tcs_i (tcs_min_i),  .twp_i (twp_min_i),  .tdh_i (tdh_min_i),
    .tch_i (tch_min_i),  .tclh_i(tclh_min_i), .twh_i (twh_min_i),
    .talh_i(talh_min_i), .treh_i(treh_min_i), .trp_i (trp_min_i),
    .tcea_i(tcea_max_i), .trea_i(trea_max_i),
    .rc_ok_o(rc_ok), .src_o(src_d)
  );

  // ceiling by pre-adding divisor-1; zero period falls through to saturation
  assign ceil_num = (per_q == '0) ? ns_q : ns_q + NW'(per_q) - 1'b1;
  assign div_num  = (st_q == S_DIV_NS) ? src_q[fld_q] : ceil_num;
  assign div_den  = (st_q == S_DIV_NS) ? DW'(PS_PER_NS) : DW'(per_q);

  nand_tcalc_div #(.NW(NW), .DW(DW)) u_div (
    .clk_i, .rst_ni,
    .start_i(go_q), .num_i(div_num), .den_i(div_den),
    .done_o(div_done), .quot_o(quot)
  );

  nand_tcalc_rule #(.NW(NW), .NARROW_W(4)) u_rule (
    .field_i(fld_q), .ceil_i(quot), .cnt_o(rule_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      fld_q   <= '0;
      go_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      bus16_q <= 1'b0;
      per_q   <= '0;
      src_q   <= '0;
      cnt_q   <= '0;
      ns_q    <= '0;
      ctrl_q  <= '0;
      tim_q   <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          if (!rc_ok) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            err_q   <= 1'b0;
            src_q   <= src_d;
            per_q   <= period_ns_i;
            bus16_q <= bus16_i;
            fld_q   <= '0;
            go_q    <= 1'b1;
            st_q    <= S_DIV_NS;
          end
        end
        S_DIV_NS: if (div_done) begin
          ns_q <= quot;
          go_q <= 1'b1;
          st_q <= S_DIV_CK;
        end
        S_DIV_CK: if (div_done) begin
          cnt_q[fld_q] <= rule_cnt;
          if (fld_q == LAST_FLD) begin
            st_q <= S_PACK;
          end else begin
            fld_q <= fld_q + 1'b1;
            go_q  <= 1'b1;
            st_q  <= S_DIV_NS;
          end
        end
        S_PACK: begin
          tim_q  <= {cnt_q[F_HIZ], cnt_q[F_HOLD], cnt_q[F_WAIT], cnt_q[F_SETUP]};
          ctrl_q <= {15'd0, cnt_q[F_ALE][3:0], cnt_q[F_CLR][3:0], 4'd0,
                     bus16_q, 3'b111, 1'b0};
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = st_q != S_IDLE;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign ctrl_word_o = ctrl_q;
  assign tim_word_o  = tim_q;
endmodule

// File: rtl/nand_tcalc_chk.sv
module nand_tcalc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [31:0] ctrl_word_o,
  input logic [31:0] tim_word_o
);
  // R1
  a_r1_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R1
  a_r1_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R2
  a_r2_reject_keeps_words: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> ($stable(ctrl_word_o) && $stable(tim_word_o)));
  // R11
  a_r11_words_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($stable(ctrl_word_o) && $stable(tim_word_o)));
  // R10
  a_r10_ctrl_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_word_o != 32'd0) |-> (ctrl_word_o[3:1] == 3'b111 && !ctrl_word_o[0] &&
                                ctrl_word_o[8:5] == 4'd0 && ctrl_word_o[31:17] == 15'd0));
  // R6 R7 R8
  a_r6_min_one_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_word_o != 32'd0) |-> (tim_word_o[7:0] != 8'd0 && tim_word_o[15:8] != 8'd0 &&
                                tim_word_o[23:16] != 8'd0));
endmodule

bind nand_tcalc nand_tcalc_chk u_chk (.*);

// File: tb/nand_tcalc_tb_top.sv
`timescale 1ns/1ps
module nand_tcalc_tb_top;
  localparam real CLK_NS = 5.0;

  typedef struct packed {
    logic [7:0]  per;
    logic        b16;
    logic [19:0] trc, tar, tclr, tcs, twp, tdh, tch, tclh, twh, talh, treh, trp, tcea, trea;
  } vec_t;

  localparam int NV = 5;
  // per b16 trc tar tclr tcs twp tdh tch tclh twh talh treh trp tcea trea
  localparam vec_t VECS [NV] = '{
    '{10, 0, 40000, 10000, 10000, 20000, 12000, 5000, 5000, 5000, 10000, 5000, 10000, 12000, 25000, 20000},
    '{1, 1, 50000, 100000, 3000, 900000, 1000, 700000, 0, 0, 0, 0, 0, 400000, 1000, 0},
    '{7, 0, 30000, 0, 0, 5000, 9000, 0, 0, 0, 0, 0, 0, 0, 3000, 8000},
    '{3, 1, 60000, 3999, 4000, 16999, 5500, 2999, 1000, 6001, 0, 4000, 0, 7999, 45000, 20000},
    '{25, 0, 100000, 60000, 35000, 70000, 15000, 20000, 5000, 130000, 0, 0, 1000, 40000, 30000, 25000}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] per;
  logic b16;
  logic [19:0] trc, tar, tclr, tcs, twp, tdh, tch, tclh, twh, talh, treh, trp, tcea, trea;
  logic busy, done, err;
  logic [31:0] ctrl_w, tim_w;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  nand_tcalc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .period_ns_i(per), .bus16_i(b16),
    .trc_min_i(trc), .tar_min_i(tar), .tclr_min_i(tclr), .tcs_min_i(tcs),
    .twp_min_i(twp), .tdh_min_i(tdh), .tch_min_i(tch), .tclh_min_i(tclh),
    .twh_min_i(twh), .talh_min_i(talh), .treh_min_i(treh), .trp_min_i(trp),
    .tcea_max_i(tcea), .trea_max_i(trea),
    .busy_o(busy), .done_o(done), .err_o(err), .ctrl_word_o(ctrl_w), .tim_word_o(tim_w)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int cdiv(int ps, int p);
    int ns = ps / 1000;
    return (ns + p - 1) / p;
  endfunction
  function automatic int sat(int v, int m);
    return (v > m) ? m : v;
  endfunction
  function automatic int m1(int v);
    return (v > 0) ? v - 1 : 0;
  endfunction
  function automatic int f1(int v);
    return (v == 0) ? 1 : v;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // reference from R3..R10
  function automatic logic [63:0] model(vec_t v);
    int p = int'(v.per);
    int d_cs = mx(int'(v.tcs) - int'(v.twp), 0);
    int d_ce = mx(int'(v.tcea) - int'(v.trea), 0);
    int hsrc = mx(mx(mx(int'(v.tdh), int'(v.tch)), mx(int'(v.tclh), int'(v.twh))),
                  mx(int'(v.talh), int'(v.treh)));
    int clr = sat(m1(cdiv(int'(v.tclr), p)), 15);
    int ale = sat(m1(cdiv(int'(v.tar), p)), 15);
    int hiz = sat(cdiv(d_cs, p), 255);
    int hld = sat(f1(cdiv(hsrc, p)), 255);
    int wt  = sat(f1(m1(cdiv(mx(int'(v.trp), int'(v.twp)), p))), 255);
    int stp = sat(f1(m1(cdiv(mx(d_cs, d_ce), p))), 255);
    logic [31:0] c, t;
    c = (32'(ale) << 13) | (32'(clr) << 9) | (32'(v.b16) << 4) | 32'h0000_000E;
    t = (32'(hiz) << 24) | (32'(hld) << 16) | (32'(wt) << 8) | 32'(stp);
    return {c, t};
  endfunction

  task automatic apply(vec_t v);
    per = v.per; b16 = v.b16; trc = v.trc; tar = v.tar; tclr = v.tclr; tcs = v.tcs;
    twp = v.twp; tdh = v.tdh; tch = v.tch; tclh = v.tclh; twh = v.twh; talh = v.talh;
    treh = v.treh; trp = v.trp; tcea = v.tcea; trea = v.trea;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // returns at the negedge where done_o is high
  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk); n++;
    end
    if (!done) chk({req, " done timeout"}, 32'd0, 32'd1);
  endtask

  task automatic run_and_check(vec_t v, string req);
    logic [63:0] e;
    e = model(v);
    apply(v);
    pulse_start();
    wait_done(req);
    chk({req, " ctrl"}, ctrl_w, e[63:32]);
    chk({req, " tim"}, tim_w, e[31:0]);
    chk({req, " err"}, 32'(err), 32'd0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", 32'(busy), 0);
    chk("R12 done", 32'(done), 0);
    chk("R12 err", 32'(err), 0);
    chk("R12 ctrl", ctrl_w, 0);
    chk("R12 tim", tim_w, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_and_check(VECS[i], $sformatf("R3-vec%0d", i));

    // R4 R6 R7 R8 R9 R10 hand-derived values for the first vector
    run_and_check(VECS[0], "R9");
    chk("R9 tim hand", tim_w, 32'h0101_0101);
    chk("R10 ctrl hand", ctrl_w, 32'h0000_000E);
    // R5 zero hiz, R8 setup forced to one, R4 zero
    run_and_check(VECS[2], "R5");
    chk("R5 hiz zero", {24'd0, tim_w[31:24]}, 32'd0);
    chk("R8 setup forced", {24'd0, tim_w[7:0]}, 32'd1);
    // R4 R6 R7 saturation, R10 bus16
    run_and_check(VECS[1], "R4");
    chk("R4 ale sat", {28'd0, ctrl_w[16:13]}, 32'd15);
    chk("R6 hold sat", {24'd0, tim_w[23:16]}, 32'd255);
    chk("R7 wait sat", {24'd0, tim_w[15:8]}, 32'd255);
    chk("R10 bus16", {31'd0, ctrl_w[4]}, 32'd1);

    // R1 done is a single-cycle pulse
    @(negedge clk);
    chk("R1 done pulse", 32'(done), 0);

    // R2 rejection keeps previous words
    v = VECS[0]; v.trc = 20'd29999;
    apply(v);
    pulse_start();
    wait_done("R2");
    chk("R2 err set", 32'(err), 1);
    chk("R2 ctrl kept", ctrl_w, model(VECS[1])[63:32]);
    chk("R2 tim kept", tim_w, model(VECS[1])[31:0]);
    v.trc = 20'd30000;
    run_and_check(v, "R2 boundary");

    // R1 R11 second start mid-run and input changes are ignored
    apply(VECS[4]);
    pulse_start();
    apply(VECS[1]);
    repeat (20) @(negedge clk);
    chk("R1 busy mid", 32'(busy), 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done("R11");
    chk("R11 ctrl", ctrl_w, model(VECS[4])[63:32]);
    chk("R11 tim", tim_w, model(VECS[4])[31:0]);
    chk("R1 busy at done", 32'(busy), 0);
    repeat (40) @(negedge clk);
    chk("R11 no second done", 32'(busy), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule